// File: doc/BRIEF.md
# Frequency-Coded Beam Current Monitor

This block turns the pulse trains of two beam-current transformer channels into current readings and checks them against interlock limits. Each channel delivers a digital pulse stream whose rate is proportional to the measured current, together with range-select bits that set the scale. The block measures the interval between successive rising edges in clock cycles, converts each interval into a current sample, and applies a range shift to it. Only intervals that lie fully inside the macro-pulse gate count.

Two checks run on every channel. The fast check compares each individual sample with a fast limit while the macro pulse is in progress. The slow check acts when the macro pulse ends. At that point the samples of that pulse are averaged and the average is compared with a slow limit. The averages of all channels leave the block together as one beat on a valid/ready stream. The two interlock flags are plain level outputs that never wait for the stream.

Stream rules: `avg_valid` rises once the averaging of a macro pulse completes. While `avg_ready` is low, `avg_valid` and `avg_data` hold. If a newer result completes before the pending one has been accepted, the newer one replaces it and `avg_valid` stays high. The block never stalls a measurement because of back-pressure.

Top module: `fcm_beam_monitor`

## Requirements
- R1: The period P of a channel is the number of clock cycles between two consecutive rising edges of its pulse input. P saturates at 2^PW-1, which is 1023 by default. Each period gives one sample, floor(NUM_K / P) shifted left by the channel's range bits, with NUM_K = 4096 by default. The range bits are taken in the cycle in which the ending edge is detected.
- R2: A period is used only if both of its rising edges are detected while `gate` is high. The first edge inside a gate only arms the channel. Edges while `gate` is low have no effect on samples, trips or averages.
- R3: `fast_trip[k]` goes high when any sample of channel k exceeds `fast_limit`. It then stays high until the next macro pulse begins, when it is cleared.
- R4: When the gate falls, the block reports per channel the floor of the sum of that macro pulse's samples divided by their count. With no samples the average is 0.
- R5: `slow_trip[k]` is set to (average > `slow_limit`) when each average is produced. It holds its value until the next average.
- R6: `avg_valid` rises with each new result. While `avg_ready` is low, valid and data hold unless a newer result arrives, which replaces the pending one. One cycle with `avg_ready` high while valid clears `avg_valid`.
- R7: Channels are independent. Channel k's average occupies `avg_data[k*CW +: CW]` (CW = 16), and its trips use bit k.
- R8: During and right after reset, all trips and `avg_valid` are 0.
- R9: A sample equal to `fast_limit`, or an average equal to `slow_limit`, does not trip.
- R10: A period longer than 1023 cycles yields the sample of P = 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_in | input | NCH | Frequency-coded pulse streams, one per channel, asynchronous |
| range_sel | input | NCH*RW | Range-select bits, RW per channel |
| gate | input | 1 | Macro-pulse gate, synchronous to clk |
| fast_limit | input | CW | Per-sample current limit |
| slow_limit | input | CW | Average current limit |
| fast_trip | output | NCH | Fast interlock flags |
| slow_trip | output | NCH | Slow interlock flags |
| avg_valid | output | 1 | Average result valid |
| avg_ready | input | 1 | Consumer accepts the result |
| avg_data | output | NCH*CW | Averaged currents, channel k in bits k*CW upward |

## Verification
The assertions assume the following about the inputs:
- `gate` is synchronous to the clock.
- Each pulse level lasts at least two cycles, so the synchronizer sees every edge.
- Consecutive gate falls lie further apart than the divider latency of about 35 cycles, so one averaging never overlaps the next.

The bench keeps to these assumptions. It changes inputs only on falling clock edges, uses pulse periods of at least four cycles, and waits 60 cycles after every gate fall. It also injects fast pulse bursts while the gate is low, to show that edges outside the gate have no effect.

// File: rtl/fcm_pkg.sv
package fcm_pkg;
  typedef enum logic {DIV_IDLE, DIV_BUSY} div_state_e;
endpackage

// File: rtl/fcm_edge_sync.sv
module fcm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/fcm_period_meter.sv
module fcm_period_meter #(
  parameter int PW    = 10,
  parameter int RW    = 2,
  parameter int CW    = 16,
  parameter int NUM_K = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise,
  input  logic          gate,
  input  logic [RW-1:0] rng,
  output logic          s_valid,
  output logic [CW-1:0] sample
);
  localparam logic [PW-1:0] PMAX  = {PW{1'b1}};
  localparam logic [CW-1:0] NUM_C = CW'(NUM_K);

  logic [PW-1:0] cnt;
  logic          armed;
  logic          p_valid;
  logic [PW-1:0] p_q;
  logic [RW-1:0] r_q;
  logic [CW-1:0] quot;
  logic          take;

  assign take = rise & gate & armed;
  assign quot = NUM_C / {{(CW-PW){1'b0}}, p_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= PW'(1);
    end else if (rise) begin
      cnt <= PW'(1);
    end else if (cnt != PMAX) begin
      cnt <= cnt + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     armed <= 1'b0;
    else if (!gate) armed <= 1'b0;
    else if (rise)  armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_valid <= 1'b0;
      p_q     <= PW'(1);
      r_q     <= '0;
      s_valid <= 1'b0;
      sample  <= '0;
    end else begin
      p_valid <= take;
      if (take) begin
        p_q <= cnt;
        r_q <= rng;
      end
      s_valid <= p_valid;
      if (p_valid) sample <= quot << r_q;
    end
  end
endmodule

// File: rtl/fcm_avg_div.sv
module fcm_avg_div
  import fcm_pkg::*;
#(
  parameter int NW = 28,
  parameter int DW = 12,
  parameter int QW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic          done,
  output logic [QW-1:0] quotient
);
  localparam int IW = $clog2(NW + 1);

  div_state_e    state;
  logic [IW-1:0] iter;
  logic [NW-1:0] work;
  logic [DW-1:0] rem;
  logic [DW-1:0] dvs;
  logic [DW:0]   rem_sh;
  logic          fits;

  assign rem_sh   = {rem, work[NW-1]};
  assign fits     = rem_sh >= {1'b0, dvs};
  assign quotient = (dvs == '0) ? '0 : QW'(work);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= DIV_IDLE;
      iter  <= '0;
      work  <= '0;
      rem   <= '0;
      dvs   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        state <= DIV_BUSY;
        iter  <= '0;
        work  <= dividend;
        rem   <= '0;
        dvs   <= divisor;
      end else if (state == DIV_BUSY) begin
        if (fits) begin
          rem  <= DW'(rem_sh - {1'b0, dvs});
          work <= {work[NW-2:0], 1'b1};
        end else begin
          rem  <= DW'(rem_sh);
          work <= {work[NW-2:0], 1'b0};
        end
        iter <= iter + IW'(1);
        if (iter == IW'(NW - 1)) begin
          state <= DIV_IDLE;
          done  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fcm_channel.sv
module fcm_channel #(
  parameter int PW    = 10,
  parameter int RW    = 2,
  parameter int CW    = 16,
  parameter int CNT_W = 12,
  parameter int NUM_K = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pulse,
  input  logic [RW-1:0] rng,
  input  logic          gate,
  input  logic [CW-1:0] fast_lim,
  input  logic [CW-1:0] slow_lim,
  output logic          fast_trip,
  output logic          slow_trip,
  output logic          done,
  output logic [CW-1:0] avg
);
  localparam int               SUM_W = CW + CNT_W;
  localparam logic [CNT_W-1:0] CMAX  = {CNT_W{1'b1}};

  logic             rise;
  logic             s_valid;
  logic [CW-1:0]    sample;
  logic             g1, g2, g3;
  logic             g_rise, g_fall;
  logic [SUM_W-1:0] sum;
  logic [CNT_W-1:0] cnt;

  fcm_edge_sync #(.STAGES(2)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .din (pulse),
    .rise (rise)
  );

  fcm_period_meter #(.PW(PW), .RW(RW), .CW(CW), .NUM_K(NUM_K)) u_meter (
    .clk (clk),
    .rst_n (rst_n),
    .rise (rise),
    .gate (gate),
    .rng (rng),
    .s_valid (s_valid),
    .sample (sample)
  );

  // gate delayed to line up with the two-stage sample pipeline
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {g1, g2, g3} <= '0;
    else        {g1, g2, g3} <= {gate, g1, g2};
  end

  assign g_rise = g2 & ~g3;
  assign g_fall = ~g2 & g3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum <= '0;
      cnt <= '0;
    end else if (g_fall) begin
      sum <= '0;
      cnt <= '0;
    end else if (s_valid && cnt != CMAX) begin
      sum <= sum + SUM_W'(sample);
      cnt <= cnt + CNT_W'(1);
    end
  end

  fcm_avg_div #(.NW(SUM_W), .DW(CNT_W), .QW(CW)) u_div (
    .clk (clk),
    .rst_n (rst_n),
    .start (g_fall),
    .dividend (sum),
    .divisor (cnt),
    .done (done),
    .quotient (avg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast_trip <= 1'b0;
    end else if (s_valid && sample > fast_lim) begin
      fast_trip <= 1'b1;
    end else if (g_rise) begin
      fast_trip <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    slow_trip <= 1'b0;
    else if (done) slow_trip <= avg > slow_lim;
  end
endmodule

// File: rtl/fcm_beam_monitor.sv
module fcm_beam_monitor #(
  parameter int NCH   = 2,
  parameter int PW    = 10,
  parameter int RW    = 2,
  parameter int CW    = 16,
  parameter int CNT_W = 12,
  parameter int NUM_K = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    pulse_in,
  input  logic [NCH*RW-1:0] range_sel,
  input  logic              gate,
  input  logic [CW-1:0]     fast_limit,
  input  logic [CW-1:0]     slow_limit,
  output logic [NCH-1:0]    fast_trip,
  output logic [NCH-1:0]    slow_trip,
  output logic              avg_valid,
  input  logic              avg_ready,
  output logic [NCH*CW-1:0] avg_data
);
  logic [NCH-1:0]    done_v;
  logic [NCH*CW-1:0] avg_v;
  logic              res_done;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    fcm_channel #(
      .PW(PW), .RW(RW), .CW(CW), .CNT_W(CNT_W), .NUM_K(NUM_K)
    ) u_ch (
      .clk (clk),
      .rst_n (rst_n),
      .pulse (pulse_in[k]),
      .rng (range_sel[k*RW +: RW]),
      .gate (gate),
      .fast_lim (fast_limit),
      .slow_lim (slow_limit),
      .fast_trip (fast_trip[k]),
      .slow_trip (slow_trip[k]),
      .done (done_v[k]),
      .avg (avg_v[k*CW +: CW])
    );
  end

  assign res_done = |done_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avg_valid <= 1'b0;
      avg_data  <= '0;
    end else if (res_done) begin
      avg_valid <= 1'b1;
      avg_data  <= avg_v;
    end else if (avg_ready) begin
      avg_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/fcm_beam_monitor_chk.sv
module fcm_beam_monitor_chk #(
  parameter int NCH = 2,
  parameter int CW  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              gate,
  input logic [NCH-1:0]    fast_trip,
  input logic [NCH-1:0]    slow_trip,
  input logic              avg_valid,
  input logic              avg_ready,
  input logic [NCH*CW-1:0] avg_data,
  input logic              res_done
);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    avg_valid && !avg_ready && !res_done |=> avg_valid && $stable(avg_data));

  assert_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    avg_valid && avg_ready && !res_done |=> !avg_valid);

  assert_new_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |=> avg_valid);

  assert_slow_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !res_done |=> $stable(slow_trip));

  for (genvar k = 0; k < NCH; k++) begin : g_fast
    assert_fast_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fast_trip[k]) |-> $past(gate, 3));
  end
endmodule

bind fcm_beam_monitor fcm_beam_monitor_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk (clk),
  .rst_n (rst_n),
  .gate (gate),
  .fast_trip (fast_trip),
  .slow_trip (slow_trip),
  .avg_valid (avg_valid),
  .avg_ready (avg_ready),
  .avg_data (avg_data),
  .res_done (res_done)
);

// File: tb/fcm_beam_monitor_test.sv
module fcm_beam_monitor_test;
  localparam int NCH = 2;
  localparam int RW  = 2;
  localparam int CW  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NCH-1:0]    pulse_in = '0;
  logic [NCH*RW-1:0] range_sel = '0;
  logic              gate = 1'b0;
  logic [CW-1:0]     fast_limit = '0;
  logic [CW-1:0]     slow_limit = '0;
  logic [NCH-1:0]    fast_trip;
  logic [NCH-1:0]    slow_trip;
  logic              avg_valid;
  logic              avg_ready = 1'b0;
  logic [NCH*CW-1:0] avg_data;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  fcm_beam_monitor uut (
    .clk (clk), .rst_n (rst_n), .pulse_in (pulse_in), .range_sel (range_sel),
    .gate (gate), .fast_limit (fast_limit), .slow_limit (slow_limit),
    .fast_trip (fast_trip), .slow_trip (slow_trip), .avg_valid (avg_valid),
    .avg_ready (avg_ready), .avg_data (avg_data)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R1/R10: sample from a period in cycles, saturated at 1023
  function automatic int cur(input int t, input int r);
    int p;
    p = (t > 1023) ? 1023 : t;
    return (4096 / p) << r;
  endfunction

  task automatic train(input int ch, input int ta, input int tb, input int n);
    for (int i = 0; i < n; i++) begin
      int t;
      t = (i % 2 == 1) ? tb : ta;
      pulse_in[ch] = 1'b1;
      repeat (t / 2) @(negedge clk);
      pulse_in[ch] = 1'b0;
      repeat (t - t / 2) @(negedge clk);
    end
  endtask

  task automatic consume();
    @(negedge clk);
    avg_ready = 1'b1;
    @(negedge clk);
    avg_ready = 1'b0;
    chk("R6 accept clears valid", avg_valid, 0);
  endtask

  // one macro pulse; ch0 periods ta0/tb0, ch1 periods ta1/tb1 (alternating)
  task automatic macro(input int ta0, input int tb0, input int ta1, input int tb1,
                       input int n, input int r0, input int r1,
                       input int fdel, input int sdel, input bit noise,
                       output int avg0, output int avg1);
    int sum[2], mx[2], cnt, av[2], fl, sl;
    int ta[2], tb[2];
    ta[0] = ta0; tb[0] = tb0; ta[1] = ta1; tb[1] = tb1;
    cnt = n - 1;
    for (int c = 0; c < 2; c++) begin
      sum[c] = 0; mx[c] = 0;
      for (int i = 0; i < n - 1; i++) begin
        int s;
        s = cur((i % 2 == 1) ? tb[c] : ta[c], (c == 0) ? r0 : r1);
        sum[c] += s;
        if (s > mx[c]) mx[c] = s;
      end
      av[c] = (cnt > 0) ? sum[c] / cnt : 0;
    end
    fl = (mx[0] - fdel < 0) ? 0 : mx[0] - fdel;
    sl = (av[0] - sdel < 0) ? 0 : av[0] - sdel;
    if (noise) begin
      // R2: edges with the gate low are ignored
      fork
        train(0, 4, 4, 6);
        train(1, 4, 4, 6);
      join
      repeat (5) @(negedge clk);
    end
    @(negedge clk);
    fast_limit = CW'(fl);
    slow_limit = CW'(sl);
    range_sel = {RW'(r1), RW'(r0)};
    gate = 1'b1;
    repeat (3) @(negedge clk);
    fork
      train(0, ta0, tb0, n);
      train(1, ta1, tb1, n);
    join
    repeat (6) @(negedge clk);
    gate = 1'b0;
    if (noise) begin
      fork
        train(0, 4, 4, 4);
        train(1, 4, 4, 4);
      join
    end
    repeat (60) @(negedge clk);
    chk("R6 valid after result", avg_valid, 1);
    chk("R4 R1 R10 avg ch0", avg_data[0 +: CW], av[0]);
    chk("R7 R2 avg ch1", avg_data[CW +: CW], av[1]);
    chk("R3 R9 fast ch0", fast_trip[0], mx[0] > fl);
    chk("R3 R7 fast ch1", fast_trip[1], mx[1] > fl);
    chk("R5 R9 slow ch0", slow_trip[0], av[0] > sl);
    chk("R5 R7 slow ch1", slow_trip[1], av[1] > sl);
    avg0 = av[0];
    avg1 = av[1];
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int tv[10];
    int a0, a1, b0, b1;
    tv = '{4, 6, 9, 13, 20, 33, 60, 127, 500, 1200};
    repeat (4) @(negedge clk);
    chk("R8 fast in reset", fast_trip, 0);
    chk("R8 slow in reset", slow_trip, 0);
    chk("R8 valid in reset", avg_valid, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 valid after reset", avg_valid, 0);
    chk("R8 trips after reset", {fast_trip, slow_trip}, 0);

    for (int ti = 0; ti < 10; ti++) begin
      for (int r = 0; r < 4; r++) begin
        macro(tv[ti], tv[ti], tv[9 - ti], tv[9 - ti] + 5, 5, r, 3 - r,
              r % 2, (r / 2) % 2, ti % 2 == 1, a0, a1);
        consume();
      end
    end

    // R4: a single edge gives no period, average 0
    macro(8, 8, 8, 8, 1, 1, 1, 0, 0, 1'b1, a0, a1);
    consume();

    // R6: hold under back-pressure, then replacement by a newer result
    macro(10, 10, 12, 12, 4, 0, 0, 1, 1, 1'b0, a0, a1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R6 valid held", avg_valid, 1);
      chk("R6 data held", avg_data, {CW'(a1), CW'(a0)});
    end
    macro(25, 25, 7, 7, 4, 2, 1, 0, 0, 1'b0, b0, b1);
    chk("R6 replaced ch0", avg_data[0 +: CW], b0);
    chk("R6 replaced ch1", avg_data[CW +: CW], b1);
    consume();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule